// File: doc/BRIEF.md
# Multicast hash address filter

This block sits on the receive path and makes an accept or reject call for each incoming frame from its destination address. The address arrives one byte per clock, first byte marked by a start strobe. While the bytes stream in, a byte-wide engine folds them into a reflected Ethernet CRC-32. Once the sixth byte has been absorbed, the result is complemented and bit-reversed. The top six bits of that reversed value form an index into a 64-bit hash table held as two 32-bit words.

A destination with its group bit set is a multicast frame. It is accepted when the indexed table bit is one, or when the promiscuous-multicast control is high. A destination without the group bit is handed on as accepted, so that a later stage can do the unicast matching. The index itself is also driven out, so that software can learn which table bit an address maps to.

Software manages the table through three ports. It can overwrite a whole word, set one bit by index (an OR into the table), or clear the whole table. A separate port reads any word back.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash is the LSB-first CRC-32 with polynomial 0xEDB88320, seeded with 0xFFFFFFFF. It covers exactly the first six bytes of a frame, each taken least significant bit first. Bytes after the sixth have no effect on the result.
- R2: `dec_index` is the top six bits of the bit-reversed complement of the CRC. Its bit 5 is the complement of CRC bit 0, and its bit 0 is the complement of CRC bit 5. Index bit 5 selects the table word (0 or 1), and index bits 4:0 select the bit within that word.
- R3: With `promisc_mc` low, a frame whose first byte has bit 0 set reports `dec_is_mcast`=1. It reports `dec_accept`=1 exactly when the indexed table bit is 1.
- R4: With `promisc_mc` high, every multicast frame reports `dec_accept`=1, whatever the table holds.
- R5: A frame whose first byte has bit 0 clear reports `dec_is_mcast`=0 and `dec_accept`=1.
- R6: `dec_valid` pulses high for exactly one cycle: the cycle after the clock edge that takes in the sixth byte. Bytes that arrive outside a started frame produce no pulse.
- R7: A pulse on `tbl_set_en` ORs table bit `tbl_set_idx` (word = bit 5, bit = bits 4:0) into the table one cycle later, and leaves every other bit unchanged.
- R8: A pulse on `tbl_wr_en` replaces word `tbl_wr_sel` with `tbl_wr_data`. `tbl_rd_data` returns word `tbl_rd_sel` combinationally.
- R9: A pulse on `tbl_clr` zeroes both words on the next edge. A clear overrides a word write or a bit set in the same cycle.
- R10: Reset zeroes both table words and holds `dec_valid` low.
- R11: A start strobe that arrives mid-address restarts the hash from the seed with that byte as the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | A byte is present on `byte_data` |
| frame_start | input | 1 | Marks the first byte of a frame (qualified by `byte_valid`) |
| byte_data | input | 8 | Destination address byte, first byte first |
| promisc_mc | input | 1 | Accept all multicast frames |
| tbl_clr | input | 1 | Clear the whole hash table |
| tbl_wr_en | input | 1 | Write one table word |
| tbl_wr_sel | input | 1 | Word selected for write |
| tbl_wr_data | input | 32 | Write data |
| tbl_set_en | input | 1 | OR one table bit in |
| tbl_set_idx | input | 6 | Index of the bit to set |
| tbl_rd_sel | input | 1 | Word selected for read |
| tbl_rd_data | output | 32 | Read data |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted (valid with `dec_valid`) |
| dec_is_mcast | output | 1 | Destination has the group bit set (valid with `dec_valid`) |
| dec_index | output | 6 | Hash index of the last hashed address |

## Verification
The bench builds the block with its default parameters: two 32-bit words and a six-byte address. This gives a six-bit index, and each word of the table can be driven and read on its own. A bit-serial CRC model in the bench predicts the index of several multicast addresses, and the bench keeps its own copy of the table. Together these make hits and misses in both words reachable, as well as trailing bytes, restarted addresses, orphan bytes and the clear-versus-write priority.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

    // Fold one byte into a reflected CRC, least significant bit first.
    function automatic logic [31:0] crc_fold_byte(input logic [31:0] c_in,
                                                  input logic [7:0]  d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int k = 0; k < 8; k++) begin
            fb = c[0] ^ d[k];
            c  = {1'b0, c[31:1]} ^ (fb ? CRC_POLY : 32'h0);
        end
        return c;
    endfunction

endpackage

// File: rtl/mhf_crc_byte.sv
module mhf_crc_byte
    import mhf_pkg::*;
#(
    parameter int OUT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             restart,
    input  logic [7:0]       data_in,
    output logic [OUT_W-1:0] crc_low
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_st_t;

    crc_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (step_en) begin
            s_d.crc = crc_fold_byte(restart ? CRC_SEED : s_q.crc, data_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{crc: CRC_SEED};
        else        s_q <= s_d;
    end

    assign crc_low = s_q.crc[OUT_W-1:0];

endmodule

// File: rtl/mhf_hash_index.sv
module mhf_hash_index #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] crc_low,
    output logic [IDX_W-1:0] idx
);

    // Top bits of the reversed complement: reversed bit 31-i is ~crc[i].
    for (genvar i = 0; i < IDX_W; i++) begin : g_rev
        assign idx[IDX_W-1-i] = ~crc_low[i];
    end

endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
    parameter int WORDS  = 2,
    parameter int WORD_W = 32,
    localparam int TOTAL = WORDS * WORD_W,
    localparam int IDX_W = $clog2(TOTAL),
    localparam int SEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  look_idx,
    output logic              look_hit
);

    typedef struct packed {
        logic [TOTAL-1:0] bits;
    } tbl_st_t;

    tbl_st_t          s_d, s_q;
    logic [TOTAL-1:0] set_mask;

    assign set_mask = set_en ? (TOTAL'(1) << set_idx) : '0;

    always_comb begin
        s_d = s_q;
        for (int w = 0; w < WORDS; w++) begin
            if (wr_en && wr_sel == SEL_W'(w)) s_d.bits[w*WORD_W +: WORD_W] = wr_data;
        end
        s_d.bits = s_d.bits | set_mask;
        if (clr) s_d.bits = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{bits: '0};
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (rd_sel == SEL_W'(w)) rd_data = s_q.bits[w*WORD_W +: WORD_W];
        end
    end

    assign look_hit = s_q.bits[look_idx];

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.bits == '0));

    // R7
    set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr) |=> s_q.bits[$past(set_idx)]);

    // R7
    set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !wr_en && !clr) |=>
            ((s_q.bits & ~$past(set_mask)) == ($past(s_q.bits) & ~$past(set_mask))));

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
    parameter int TABLE_WORDS = 2,
    parameter int WORD_W      = 32,
    parameter int ADDR_BYTES  = 6,
    localparam int IDX_W = $clog2(TABLE_WORDS * WORD_W),
    localparam int SEL_W = $clog2(TABLE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic              frame_start,
    input  logic [7:0]        byte_data,
    input  logic              promisc_mc,
    input  logic              tbl_clr,
    input  logic              tbl_wr_en,
    input  logic [SEL_W-1:0]  tbl_wr_sel,
    input  logic [WORD_W-1:0] tbl_wr_data,
    input  logic              tbl_set_en,
    input  logic [IDX_W-1:0]  tbl_set_idx,
    input  logic [SEL_W-1:0]  tbl_rd_sel,
    output logic [WORD_W-1:0] tbl_rd_data,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic              dec_is_mcast,
    output logic [IDX_W-1:0]  dec_index
);

    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;   // bytes taken so far; CNT_IDLE when none expected
        logic             mc;
        logic             dv;
    } fr_st_t;

    fr_st_t           s_d, s_q;
    logic [CNT_W-1:0] pos;
    logic             addr_byte;
    logic [IDX_W-1:0] crc_low;
    logic             hit;

    assign pos       = frame_start ? '0 : s_q.cnt;
    assign addr_byte = byte_valid && (frame_start || s_q.cnt != CNT_IDLE);

    always_comb begin
        s_d    = s_q;
        s_d.dv = 1'b0;
        if (addr_byte) begin
            s_d.cnt = pos + 1'b1;
            if (frame_start) s_d.mc = byte_data[0];
            if (pos == CNT_LAST) s_d.dv = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: CNT_IDLE, mc: 1'b0, dv: 1'b0};
        else        s_q <= s_d;
    end

    mhf_crc_byte #(.OUT_W(IDX_W)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (addr_byte),
        .restart (frame_start),
        .data_in (byte_data),
        .crc_low (crc_low)
    );

    mhf_hash_index #(.IDX_W(IDX_W)) u_idx (
        .crc_low (crc_low),
        .idx     (dec_index)
    );

    mhf_table #(.WORDS(TABLE_WORDS), .WORD_W(WORD_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tbl_clr),
        .wr_en    (tbl_wr_en),
        .wr_sel   (tbl_wr_sel),
        .wr_data  (tbl_wr_data),
        .set_en   (tbl_set_en),
        .set_idx  (tbl_set_idx),
        .rd_sel   (tbl_rd_sel),
        .rd_data  (tbl_rd_data),
        .look_idx (dec_index),
        .look_hit (hit)
    );

    assign dec_valid    = s_q.dv;
    assign dec_is_mcast = s_q.dv & s_q.mc;
    assign dec_accept   = s_q.dv & (s_q.mc ? (promisc_mc | hit) : 1'b1);

    // R6
    dv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R6
    dv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(byte_valid));

    // R4
    promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_is_mcast && promisc_mc) |-> dec_accept);

    // R5
    ucast_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_is_mcast) |-> dec_accept);

endmodule

// File: tb/sim_mcast_hash_filter.sv
module sim_mcast_hash_filter;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0, frame_start = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        promisc_mc = 1'b0;
    logic        tbl_clr = 1'b0, tbl_wr_en = 1'b0, tbl_set_en = 1'b0;
    logic        tbl_wr_sel = 1'b0, tbl_rd_sel = 1'b0;
    logic [31:0] tbl_wr_data = '0;
    logic [5:0]  tbl_set_idx = '0;
    logic [31:0] tbl_rd_data;
    logic        dec_valid, dec_accept, dec_is_mcast;
    logic [5:0]  dec_index;

    int checks = 0, failures = 0;
    int pulses = 0;
    logic       cap_acc, cap_mc;
    logic [5:0] cap_idx;
    logic [63:0] shadow = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcast_hash_filter u0 (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .frame_start(frame_start),
        .byte_data(byte_data), .promisc_mc(promisc_mc), .tbl_clr(tbl_clr),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_sel(tbl_wr_sel), .tbl_wr_data(tbl_wr_data),
        .tbl_set_en(tbl_set_en), .tbl_set_idx(tbl_set_idx), .tbl_rd_sel(tbl_rd_sel),
        .tbl_rd_data(tbl_rd_data), .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_is_mcast(dec_is_mcast), .dec_index(dec_index)
    );

    always @(negedge clk) begin
        if (dec_valid) begin
            pulses++;
            cap_acc = dec_accept;
            cap_mc  = dec_is_mcast;
            cap_idx = dec_index;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Independent bit-serial reference of the hash index.
    function automatic logic [5:0] ref_index(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        logic [31:0] inv;
        for (int b = 0; b < 6; b++) begin
            logic [7:0] d = a[47-8*b -: 8];
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ d[k]) c = (c >> 1) ^ 32'hEDB88320;
                else             c = c >> 1;
            end
        end
        inv = ~c;
        return {inv[0], inv[1], inv[2], inv[3], inv[4], inv[5]};
    endfunction

    task automatic send(input logic [47:0] a, input int extra, input logic with_start);
        for (int i = 0; i < 6 + extra; i++) begin
            @(negedge clk);
            byte_valid  = 1'b1;
            frame_start = with_start && (i == 0);
            byte_data   = (i < 6) ? a[47-8*i -: 8] : 8'h3C;
        end
        @(negedge clk);
        byte_valid = 1'b0; frame_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_word(input logic sel, output logic [31:0] v);
        tbl_rd_sel = sel;
        #1 v = tbl_rd_data;
    endtask

    task automatic set_bit(input logic [5:0] i);
        @(negedge clk); tbl_set_en = 1'b1; tbl_set_idx = i;
        @(negedge clk); tbl_set_en = 1'b0;
        shadow[i] = 1'b1;
    endtask

    task automatic clear_all();
        @(negedge clk); tbl_clr = 1'b1;
        @(negedge clk); tbl_clr = 1'b0;
        shadow = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R10", "dec_valid after reset", dec_valid, 0);
        read_word(0, v); check("R10", "word0 after reset", v, 0);
        read_word(1, v); check("R10", "word1 after reset", v, 0);
    endtask

    task automatic t_frame(input logic [47:0] a, input logic promisc);
        int p0;
        logic [5:0] ei = ref_index(a);
        logic mc = a[40];
        promisc_mc = promisc;
        p0 = pulses;
        send(a, 0, 1'b1);
        check("R6", "one decision pulse", pulses - p0, 1);
        check("R1", "hash index", cap_idx, ei);
        check("R2", "index vs reference", cap_idx, ei);
        check(mc ? "R3" : "R5", "is_mcast", cap_mc, mc);
        if (!mc)          check("R5", "unicast accept", cap_acc, 1);
        else if (promisc) check("R4", "promisc accept", cap_acc, 1);
        else              check("R3", "table accept", cap_acc, shadow[ei]);
        promisc_mc = 1'b0;
    endtask

    task automatic t_hit_both_words();
        logic [47:0] a1 = 48'h01005E000001;
        logic [47:0] a2 = 48'h333300000001;
        logic [47:0] a3 = 48'h01005E7F0203;
        logic [31:0] v;
        t_frame(a1, 0);
        t_frame(a2, 0);
        set_bit(ref_index(a1));
        set_bit(ref_index(a3));
        read_word(ref_index(a1) >> 5, v);
        check("R7", "set bit visible", v, shadow[32*ref_index(a1)[5] +: 32]);
        t_frame(a1, 0);
        t_frame(a2, 0);
        t_frame(a3, 0);
        t_frame(48'hFFFFFFFFFFFF, 0);
    endtask

    task automatic t_write_and_or();
        logic [31:0] v;
        clear_all();
        @(negedge clk); tbl_wr_en = 1'b1; tbl_wr_sel = 1'b1; tbl_wr_data = 32'hA5A50F0F;
        @(negedge clk); tbl_wr_en = 1'b0;
        shadow[63:32] = 32'hA5A50F0F;
        read_word(1, v); check("R8", "word1 write", v, 32'hA5A50F0F);
        read_word(0, v); check("R8", "word0 untouched", v, 0);
        set_bit(6'd36);
        read_word(1, v); check("R7", "OR keeps others", v, 32'hA5A50F1F);
        set_bit(6'd0);
        read_word(0, v); check("R7", "set in word0", v, 32'h1);
        read_word(1, v); check("R7", "word1 kept", v, 32'hA5A50F1F);
    endtask

    task automatic t_promisc();
        clear_all();
        t_frame(48'h01005E000001, 1);
        t_frame(48'h01005E000001, 0);
        t_frame(48'h0050C2123456, 1);
    endtask

    task automatic t_extra_and_orphan();
        int p0 = pulses;
        send(48'h01005E0A0B0C, 5, 1'b1);
        check("R6", "pulse with trailing bytes", pulses - p0, 1);
        check("R1", "trailing bytes ignored", cap_idx, ref_index(48'h01005E0A0B0C));
        p0 = pulses;
        send(48'h01005E0A0B0C, 4, 1'b0);
        check("R6", "orphan bytes no pulse", pulses - p0, 0);
    endtask

    task automatic t_restart();
        int p0 = pulses;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; frame_start = (i == 0); byte_data = 8'h91 + 8'(i);
        end
        send(48'h01005E112233, 0, 1'b1);
        check("R11", "restart single pulse", pulses - p0, 1);
        check("R11", "restart index", cap_idx, ref_index(48'h01005E112233));
    endtask

    task automatic t_clr_priority();
        logic [31:0] v;
        @(negedge clk);
        tbl_clr = 1'b1; tbl_wr_en = 1'b1; tbl_wr_sel = 1'b0; tbl_wr_data = 32'hFFFF0000;
        tbl_set_en = 1'b1; tbl_set_idx = 6'd40;
        @(negedge clk);
        tbl_clr = 1'b0; tbl_wr_en = 1'b0; tbl_set_en = 1'b0;
        shadow = '0;
        read_word(0, v); check("R9", "clear beats write", v, 0);
        read_word(1, v); check("R9", "clear beats set", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_hit_both_words();
        t_write_and_or();
        t_promisc();
        t_extra_and_orphan();
        t_restart();
        t_clr_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule